// File: doc/BRIEF.md
# Interrupt Vector Receive Unit

The unit collects up to 64 vector interrupt lines and 16 legacy bus IRQ lines, and hands the processor one vector interrupt at a time. A fixed table maps five legacy IRQ numbers onto vector lines. The other legacy numbers have no vector and are discarded. The unit has a single slot. While that slot is full, a busy flag is held high and a vector-trap request goes to the core. Three 64-bit data words describe the interrupt that was accepted.

A request is taken only on a rising edge of an effective request line, and only while the unit is idle. When the accepted line falls, the slot is released and the trap request is withdrawn. A small read port lets software read the status word and the three data words.

Top module: `intvec_rx`

## Requirements
- R1: A synchronous active-high `rst` clears `busy`, `trap_req`, `trap_type` and all three data words to zero, and forgets earlier line levels.
- R2: When an effective request line k rises while `busy` is 0, the next clock edge sets `busy` and `trap_req` to 1, and `trap_type` reads 0x060 for as long as `busy` stays 1.
- R3: On acceptance, `word0` becomes (0x1F << 6) | k, which places the tag 0x1F in bits 10:6 and k in bits 5:0. `word1` and `word2` become 0.
- R4: A rising request on any line while `busy` is 1 is ignored. `busy` and `word0` keep their values. A line that stayed high through the busy period is not accepted after release unless it falls and rises again.
- R5: When the accepted line is low at a clock edge while `busy` is 1, that edge clears `busy` and `trap_req`, and `trap_type` returns to 0. The data words keep their values until the next acceptance.
- R6: When several lines rise in the same cycle, the lowest-numbered line is accepted.
- R7: Legacy line n drives vector line v according to this table: 1→0x29, 4→0x2B, 6→0x27, 7→0x22, 12→0x2A. Dropping the legacy line releases the unit.
- R8: Legacy lines with any other number have no effect on `busy` or on the data words.
- R9: `rd_data` returns the selected word, with no clock delay, according to `rd_addr`. Address 0 returns a status word that holds `busy` in bit 5 and zeros elsewhere. Addresses 1, 2 and 3 return `word0`, `word1` and `word2`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src | input | 64 | Vector interrupt request lines, level |
| leg | input | 16 | Legacy bus IRQ lines, level |
| busy | output | 1 | Slot occupied |
| trap_req | output | 1 | Vector trap request to the core |
| trap_type | output | 9 | Trap type, 0x060 while busy, else 0 |
| word0 | output | 64 | Data word 0: tag and line number |
| word1 | output | 64 | Data word 1 (zero on acceptance) |
| word2 | output | 64 | Data word 2 (zero on acceptance) |
| rd_addr | input | 2 | Read select: status, word0, word1, word2 |
| rd_data | output | 64 | Selected read word |

## Verification
The bench raises a second line while the slot is busy. A design that queued that request, or detected levels instead of edges, would take it after release and overwrite `word0`. The bench also raises several lines in one cycle, which exposes a priority encoder that picks the highest line. It drives every legacy number: a wrong table entry would show up as a wrong line number in `word0`, and an unmapped number that leaked through would set `busy`. Finally, it checks that release depends only on the accepted line, so a design that watched any line, or cleared the data words on release, would be caught.

// File: rtl/intvec_rx.sv
module intvec_rx #(
  parameter int NSRC = 64,
  parameter int NLEG = 16,
  parameter int DW = 64,
  parameter int TT_W = 9,
  parameter logic [TT_W-1:0] TT_VEC = 9'h060,
  parameter logic [4:0] ID_TAG = 5'h1f,
  parameter int BUSY_BIT = 5
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] src,
  input  logic [NLEG-1:0] leg,
  output logic            busy,
  output logic            trap_req,
  output logic [TT_W-1:0] trap_type,
  output logic [DW-1:0]   word0,
  output logic [DW-1:0]   word1,
  output logic [DW-1:0]   word2,
  input  logic [1:0]      rd_addr,
  output logic [DW-1:0]   rd_data
);
  localparam int IW = $clog2(NSRC);

  function automatic int leg_map(input int n);
    case (n)
      1:  return 'h29;
      4:  return 'h2b;
      6:  return 'h27;
      7:  return 'h22;
      12: return 'h2a;
      default: return 0;
    endcase
  endfunction

  logic [NSRC-1:0] leg_vec, req, req_q, rise;
  logic [IW-1:0]   pick, own;
  logic            any;

  always_comb begin
    leg_vec = '0;
    for (int n = 0; n < NLEG; n++) begin
      int v;
      v = leg_map(n);
      if (v != 0 && v < NSRC && leg[n]) leg_vec[v[IW-1:0]] = 1'b1;
    end
  end

  assign req  = src | leg_vec;
  assign rise = req & ~req_q;

  always_comb begin
    pick = '0;
    any  = 1'b0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (rise[i]) begin
        pick = IW'(i);
        any  = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy  <= 1'b0;
      own   <= '0;
      word0 <= '0;
      word1 <= '0;
      word2 <= '0;
      req_q <= '0;
    end else begin
      req_q <= req;
      if (!busy && any) begin
        busy  <= 1'b1;
        own   <= pick;
        word0 <= DW'({ID_TAG, pick});
        word1 <= '0;
        word2 <= '0;
      end else if (busy && !req[own]) begin
        busy <= 1'b0;
      end
    end
  end

  assign trap_req  = busy;
  assign trap_type = busy ? TT_VEC : '0;

  always_comb begin
    case (rd_addr)
      2'd0:    rd_data = DW'(busy) << BUSY_BIT;
      2'd1:    rd_data = word0;
      2'd2:    rd_data = word1;
      default: rd_data = word2;
    endcase
  end

  // R1
  reset_clear_chk: assert property (@(posedge clk) rst |=> !busy && word0 == '0 && word1 == '0);

  // R2
  trap_on_accept_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> trap_req && trap_type == TT_VEC);

  // R3
  word_fill_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> word0[IW+4:IW] == ID_TAG && word1 == '0 && word2 == '0);

  // R4
  hold_while_busy_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && req[own]) |=> busy && $stable(word0));

  // R5
  release_owner_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> !$past(req[own]));

  // R6
  lowest_wins_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> ($past(rise) & ((NSRC'(1) << word0[IW-1:0]) - NSRC'(1))) == '0);
endmodule

// File: tb/sim_intvec_rx.sv
module sim_intvec_rx;
  logic        clk = 1'b0;
  logic        rst;
  logic [63:0] src;
  logic [15:0] leg;
  logic        busy, trap_req;
  logic [8:0]  trap_type;
  logic [63:0] word0, word1, word2, rd_data;
  logic [1:0]  rd_addr;
  int n_chk = 0;
  int n_fail = 0;

  intvec_rx u0 (.clk(clk), .rst(rst), .src(src), .leg(leg), .busy(busy),
    .trap_req(trap_req), .trap_type(trap_type), .word0(word0), .word1(word1),
    .word2(word2), .rd_addr(rd_addr), .rd_data(rd_data));

  always #2 clk = ~clk;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [63:0] s, input logic [15:0] l);
    @(negedge clk);
    src = s;
    leg = l;
    @(posedge clk);
    #1;
  endtask

  function automatic logic [63:0] w0(input int k);
    return 64'((32'h1f << 6) | k);
  endfunction

  task automatic t_reset;
    rst = 1'b1; src = '0; leg = '0; rd_addr = 2'd0;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 busy", 64'(busy), 0);
    chk("R1 trap_req", 64'(trap_req), 0);
    chk("R1 trap_type", 64'(trap_type), 0);
    chk("R1 word0", word0, 0);
    chk("R1 word1", word1, 0);
    chk("R1 word2", word2, 0);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic t_single;
    drive(64'h1 << 9, '0);
    chk("R2 busy", 64'(busy), 1);
    chk("R2 trap_req", 64'(trap_req), 1);
    chk("R2 trap_type", 64'(trap_type), 64'h060);
    chk("R3 word0", word0, w0(9));
    chk("R3 word1", word1, 0);
    chk("R3 word2", word2, 0);
    drive('0, '0);
    chk("R5 busy", 64'(busy), 0);
    chk("R5 trap_type", 64'(trap_type), 0);
    chk("R5 word0 kept", word0, w0(9));
  endtask

  task automatic t_busy_ignore;
    drive(64'h1 << 20, '0);
    drive((64'h1 << 20) | (64'h1 << 3), '0);
    chk("R4 busy", 64'(busy), 1);
    chk("R4 word0", word0, w0(20));
    drive(64'h1 << 3, '0);
    chk("R5 release", 64'(busy), 0);
    drive(64'h1 << 3, '0);
    chk("R4 held line no retrigger", 64'(busy), 0);
    chk("R4 word0 unchanged", word0, w0(20));
    drive('0, '0);
    drive(64'h1 << 3, '0);
    chk("R4 fresh edge accepted", word0, w0(3));
    drive('0, '0);
  endtask

  task automatic t_priority;
    drive((64'h1 << 63) | (64'h1 << 40) | (64'h1 << 17), '0);
    chk("R6 lowest wins", word0, w0(17));
    drive((64'h1 << 63) | (64'h1 << 40), '0);
    chk("R6 release", 64'(busy), 0);
    drive('0, '0);
    drive(64'h1 << 63, '0);
    chk("R6 top line", word0, w0(63));
    drive('0, '0);
  endtask

  task automatic t_legacy;
    int irq [5] = '{1, 4, 6, 7, 12};
    int vec [5] = '{'h29, 'h2b, 'h27, 'h22, 'h2a};
    for (int i = 0; i < 5; i++) begin
      drive('0, 16'h1 << irq[i]);
      chk("R7 legacy busy", 64'(busy), 1);
      chk("R7 legacy word0", word0, w0(vec[i]));
      drive('0, '0);
      chk("R7 legacy release", 64'(busy), 0);
    end
  endtask

  task automatic t_legacy_drop;
    drive(64'h1 << 5, '0);
    drive('0, '0);
    for (int n = 0; n < 16; n++) begin
      if (n != 1 && n != 4 && n != 6 && n != 7 && n != 12) begin
        drive('0, 16'h1 << n);
        chk("R8 dropped busy", 64'(busy), 0);
        chk("R8 dropped word0", word0, w0(5));
        drive('0, '0);
      end
    end
  endtask

  task automatic t_read;
    drive(64'h1 << 33, '0);
    rd_addr = 2'd0; #1;
    chk("R9 status busy", rd_data, 64'h20);
    rd_addr = 2'd1; #1;
    chk("R9 word0", rd_data, w0(33));
    rd_addr = 2'd2; #1;
    chk("R9 word1", rd_data, 0);
    rd_addr = 2'd3; #1;
    chk("R9 word2", rd_data, 0);
    drive('0, '0);
    rd_addr = 2'd0; #1;
    chk("R9 status idle", rd_data, 0);
  endtask

  initial begin
    #400000;
    n_fail++;
    $display("FAIL watchdog act=hung exp=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    t_reset;
    t_single;
    t_busy_ignore;
    t_priority;
    t_legacy;
    t_legacy_drop;
    t_read;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule